// File: doc/BRIEF.md
# Pipelined Binary-to-One-Hot Decoder

This block turns a binary code into a one-hot word, one word per clock, through a short fixed pipeline. The code pins are registered first. Each half of the registered code then feeds its own small one-hot predecoder, and that result is registered. A final layer of two-input AND gates pairs one line from each predecoder to form every output bit, and that layer is also registered. Because each register sits after only one level of logic, the block can run at a high clock rate. Every path from the code pins to the word pins passes through exactly three registers, so results from successive codes never mix.

The output order is reversed. Code 0 lights the top bit of the word, and the all-ones code lights bit 0. The upper half of the code picks a row, which is a group of 2^(CODE_W/2) adjacent output bits. The lower half picks the column inside that row.

A valid flag goes through the same three-stage delay as the data, so each output word lines up with the code that produced it. The stream has no back-pressure. The block takes a code on every clock, and a word appears three clocks later whether or not the consumer is ready. A consumer that cannot keep up must buffer outside the block. When the flag is low, the block is idle for that cycle and the output word is all zeros.

Top module: `onehot_decode_pipe`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `out_word` is all zeros.
- R2: A valid word for input code `c` has exactly one bit set, at index (2^CODE_W − 1 − c). With the defaults, code 0 sets bit 255 and code 255 sets bit 0.
- R3: Latency is 3 clocks. A code presented with `in_valid` = 1 before clock edge k appears on `out_word` with `out_valid` = 1 after edge k+2.
- R4: One code is accepted on every clock. Back-to-back valid codes come out on consecutive cycles, in the order they went in, with no gaps or stalls.
- R5: Whenever `out_valid` is 0, `out_word` is all zeros, whatever code was on `in_code` while `in_valid` was low.
- R6: `out_valid` copies `in_valid` from 3 clocks earlier for any pattern of gaps, including a single isolated valid cycle.
- R7: A reset that arrives while valid words are still in the pipeline throws them all away. After the reset, no stale word appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_code` as a code to be decoded this cycle |
| in_code | input | CODE_W (8) | Binary code; upper half selects the row, lower half the column |
| out_valid | output | 1 | Marks `out_word` as a decoded result |
| out_word | output | 2^CODE_W (256) | One-hot result, reversed order |

## Verification
Two events can land in the same cycle: a reset, and valid words that are still in the pipeline heading for the output. The bench drives a stream of valid codes and raises reset partway through. It then requires the first output after the reset to be all zeros with the flag low, and it requires that none of the discarded words ever shows up later. A scoreboard also compares every output cycle of a full code sweep, of back-to-back streams and of streams with gaps against the word expected from the input three cycles earlier.

// File: rtl/onehot_dec_pkg.sv
package onehot_dec_pkg;
  localparam int unsigned DEF_CODE_W = 8;

  function automatic int unsigned half_lo(input int unsigned w);
    return w / 2;
  endfunction

  function automatic int unsigned half_hi(input int unsigned w);
    return w - (w / 2);
  endfunction
endpackage

// File: rtl/onehot_nibble_predec.sv
module onehot_nibble_predec #(
  parameter int unsigned IN_W = 4,
  localparam int unsigned LINES = 1 << IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IN_W-1:0]  field,
  output logic [LINES-1:0] vec
);
  logic [LINES-1:0] vec_nxt;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      vec_nxt[i] = en && (field == IN_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vec <= '0;
    else     vec <= vec_nxt;
  end

  // R2: an enabled field yields exactly one active line next cycle
  assert_predec_single_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> ($countones(vec) == 1));
  // R5: a disabled field yields no active line next cycle
  assert_predec_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (vec == '0));
endmodule

// File: rtl/onehot_rowcol_and.sv
module onehot_rowcol_and #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned COLS = 16,
  localparam int unsigned OUT_W = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROWS-1:0]  row_vec,
  input  logic [COLS-1:0]  col_vec,
  output logic [OUT_W-1:0] word
);
  logic [OUT_W-1:0] word_nxt;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      // reversed order: row/column pair (r,c) lands at the mirrored index
      assign word_nxt[OUT_W - 1 - (r * COLS + c)] = row_vec[r] & col_vec[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word <= '0;
    else     word <= word_nxt;
  end

  // R2: the combined word never carries more than one set bit
  assert_word_atmost_one_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(word) <= 1));
endmodule

// File: rtl/onehot_decode_pipe.sv
module onehot_decode_pipe
  import onehot_dec_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned LO_W = half_lo(CODE_W),
  localparam int unsigned HI_W = half_hi(CODE_W),
  localparam int unsigned ROWS = 1 << HI_W,
  localparam int unsigned COLS = 1 << LO_W,
  localparam int unsigned OUT_W = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_word
);
  // stage 1: pin registers
  logic [CODE_W-1:0] code_q;
  logic              v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      v3     <= 1'b0;
    end else begin
      code_q <= in_code;
      v1     <= in_valid;
      v2     <= v1;
      v3     <= v2;
    end
  end

  // stage 2: per-half predecode
  logic [ROWS-1:0] row_vec;
  logic [COLS-1:0] col_vec;

  onehot_nibble_predec #(.IN_W(HI_W)) u_row (
    .clk(clk), .rst(rst), .en(v1),
    .field(code_q[CODE_W-1:LO_W]), .vec(row_vec)
  );

  onehot_nibble_predec #(.IN_W(LO_W)) u_col (
    .clk(clk), .rst(rst), .en(v1),
    .field(code_q[LO_W-1:0]), .vec(col_vec)
  );

  // stage 3: AND layer with output register
  onehot_rowcol_and #(.ROWS(ROWS), .COLS(COLS)) u_and (
    .clk(clk), .rst(rst), .row_vec(row_vec), .col_vec(col_vec), .word(out_word)
  );

  assign out_valid = v3;

  // checker: edges seen since reset, saturating at the pipeline depth
  logic [1:0] fill;
  always_ff @(posedge clk) begin
    if (rst)              fill <= '0;
    else if (fill != 2'd3) fill <= fill + 2'd1;
  end

  // R1 / R7: first cycle after reset shows an idle, empty output
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_word == '0));
  // R5: no word without the flag
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_word == '0));
  // R3 / R6: flag delayed by exactly three clocks
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (fill == 2'd3) |-> (out_valid == $past(in_valid, 3)));
  // R2: the mirrored index (all-ones minus code equals bitwise complement)
  assert_mapping_R2: assert property (@(posedge clk) disable iff (rst)
    (fill == 2'd3 && out_valid) |-> out_word[~$past(in_code, 3)]);
endmodule

// File: tb/tb_onehot_decode_pipe.sv
module tb_onehot_decode_pipe;
  localparam int CODE_W = 8;
  localparam int OUT_W  = 1 << CODE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic              out_valid;
  logic [OUT_W-1:0]  out_word;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [CODE_W:0] exp_q[$];
  string           tag_q[$];

  always #5 clk = ~clk;

  onehot_decode_pipe #(.CODE_W(CODE_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [OUT_W-1:0] expect_word(input logic v, input logic [CODE_W-1:0] c);
    logic [OUT_W-1:0] w;
    w = '0;
    if (v) w[OUT_W - 1 - int'(c)] = 1'b1;
    return w;
  endfunction

  task automatic check_out(input string tag, input logic ev, input logic [OUT_W-1:0] ew);
    vectors++;
    if (out_valid !== ev || out_word !== ew) begin
      errors++;
      $display("FAIL %s: actual valid=%0b word=%h expected valid=%0b word=%h",
               tag, out_valid, out_word, ev, ew);
    end
  endtask

  // monitor half: compare the oldest queued item; driver half: push the new one
  task automatic step(input logic v, input logic [CODE_W-1:0] c, input string tag);
    logic [CODE_W:0] it;
    string t;
    @(negedge clk);
    if (exp_q.size() == 3) begin
      it = exp_q.pop_front();
      t  = tag_q.pop_front();
      check_out(t, it[CODE_W], expect_word(it[CODE_W], it[CODE_W-1:0]));
    end
    in_valid = v;
    in_code  = c;
    exp_q.push_back({v, c});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_code = '0;
    @(negedge clk);
    check_out(tag, 1'b0, '0);
    rst = 1'b0;
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back('0);
      tag_q.push_back(tag);
    end
  endtask

  initial begin
    do_reset("R1");
    // R2 + R4: full sweep back to back
    for (int i = 0; i < OUT_W; i++) step(1'b1, CODE_W'(i), "R2");
    // R5: idle cycles carrying junk codes
    for (int i = 0; i < 6; i++) step(1'b0, CODE_W'(8'hA5 + i), "R5");
    // R3 / R6: isolated valid pulse
    step(1'b1, 8'h3C, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 8'hFF, "R6");
    // R4: alternating extremes, back to back
    for (int i = 0; i < 16; i++) step(1'b1, (i % 2) ? 8'h00 : 8'hFF, "R4");
    // R6: irregular gaps
    for (int i = 0; i < 24; i++) step((i % 3) != 1, CODE_W'(i * 37), "R6");
    // R7: reset while the pipe is full of valid words
    for (int i = 0; i < 3; i++) step(1'b1, CODE_W'(8'h10 + i), "R7");
    do_reset("R7");
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, "R7");
    step(1'b1, 8'h80, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, "R5");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule